// File: doc/BRIEF.md
# Program Counter and Exception Register Unit

This block keeps the three architectural address and status registers of a multicycle processor core: the program counter, the exception return address and the cause word. Each cycle the control sequencer picks one of four candidate next addresses. The candidates are the sequential address that the ALU has just computed, the branch target held from an earlier cycle, a jump target built from the current PC and the instruction's 26-bit target field, and a fixed exception entry address. The PC is then written either unconditionally or only when the ALU reports equal operands.

When the sequencer enters an exception step, it writes the return address into the exception register and a one-bit reason into the cause register. The return address is the faulting instruction's address, which the ALU computes as PC minus four. The ALU, memory and register file sit outside this block. Every output comes straight from a register and changes only at a rising clock edge.

Top module: `pcx_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `pc_q`, `epc_q` and `cause_q` become zero, whatever the other inputs are.
- R2: With `pc_src` = 2'b00 and a PC load, `pc_q` takes `alu_result` at the next edge.
- R3: With `pc_src` = 2'b01 and a PC load, `pc_q` takes `alu_out_reg` (the branch target held from decode).
- R4: With `pc_src` = 2'b10 and a PC load, `pc_q` takes the old `pc_q[31:28]`, followed by `ir_target[25:0]`, followed by two zero bits.
- R5: With `pc_src` = 2'b11 and a PC load, `pc_q` takes the exception entry address 32'h8000_0180.
- R6: When `pc_wr_cond` is high and `pc_wr` is low, the PC loads only if `alu_zero` is high. Otherwise it keeps its value.
- R7: When `pc_wr` and `pc_wr_cond` are both low, `pc_q` keeps its value whatever `pc_src` and `alu_zero` are.
- R8: When `pc_wr` and `pc_wr_cond` are both high, the PC loads the selected source exactly once, whatever `alu_zero` is.
- R9: When `epc_wr` is high, `epc_q` takes `alu_result`. Otherwise `epc_q` keeps its value.
- R10: When `cause_wr` is high, `cause_q` becomes `{31'b0, int_cause}`, where bit 0 is 0 for an undefined instruction and 1 for an arithmetic overflow. Otherwise `cause_q` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| alu_result | input | 32 | Combinational ALU output (PC+4 or PC-4) |
| alu_out_reg | input | 32 | Registered ALU output holding the branch target |
| ir_target | input | 26 | Target field of the instruction register |
| alu_zero | input | 1 | ALU reports equal operands |
| pc_src | input | 2 | Next-PC source select |
| pc_wr | input | 1 | Unconditional PC write |
| pc_wr_cond | input | 1 | PC write gated by alu_zero |
| epc_wr | input | 1 | Capture return address |
| cause_wr | input | 1 | Capture exception reason |
| int_cause | input | 1 | Reason: 0 undefined instruction, 1 overflow |
| pc_q | output | 32 | Program counter |
| epc_q | output | 32 | Exception return address |
| cause_q | output | 32 | Cause word |

## Verification
Each register result is due exactly one rising edge after the inputs that caused it. The bench therefore drives inputs on the falling edge and compares the outputs 1 ns after the next rising edge. The expected PC for that edge is computed from the bench's own model value before the edge. This matters for the jump source, which must use the PC as it was before the load, not after. Inputs that should have no effect are checked the same way, by comparing against the held model value at the following edge.

// File: rtl/pcx_pkg.sv
package pcx_pkg;
  localparam int XLEN  = 32;
  localparam int TGT_W = 26;
  localparam int SEG_W = XLEN - TGT_W - 2;

  typedef enum logic [1:0] {
    SRC_SEQ = 2'b00,
    SRC_BR  = 2'b01,
    SRC_JMP = 2'b10,
    SRC_EXC = 2'b11
  } pc_src_e;

  // Keep the current segment bits, replace the rest with the word-aligned target.
  function automatic logic [XLEN-1:0] jump_target(input logic [XLEN-1:0] pc,
                                                  input logic [TGT_W-1:0] tgt);
    return {pc[XLEN-1 -: SEG_W], tgt, 2'b00};
  endfunction

  function automatic logic pc_load(input logic wr, input logic wr_cond,
                                   input logic zero);
    return wr | (wr_cond & zero);
  endfunction
endpackage

// File: rtl/pcx_next_sel.sv
module pcx_next_sel
  import pcx_pkg::*;
#(
  parameter logic [XLEN-1:0] EXC_VECTOR = 32'h8000_0180
) (
  input  logic [XLEN-1:0]  pc_cur,
  input  logic [XLEN-1:0]  alu_result,
  input  logic [XLEN-1:0]  alu_out_reg,
  input  logic [TGT_W-1:0] ir_target,
  input  pc_src_e          src,
  output logic [XLEN-1:0]  pc_next
);
  always_comb begin
    unique case (src)
      SRC_SEQ: pc_next = alu_result;
      SRC_BR:  pc_next = alu_out_reg;
      SRC_JMP: pc_next = jump_target(pc_cur, ir_target);
      SRC_EXC: pc_next = EXC_VECTOR;
      default: pc_next = alu_result;
    endcase
  end
endmodule

// File: rtl/pcx_pc_reg.sv
module pcx_pc_reg
  import pcx_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic            wr_cond,
  input  logic            zero,
  input  logic [XLEN-1:0] pc_next,
  output logic [XLEN-1:0] pc_q
);
  logic branch_taken;
  logic load_en;

  assign branch_taken = wr_cond & zero;
  assign load_en      = pc_load(wr, wr_cond, zero);

  always_ff @(posedge clk) begin
    if (rst)          pc_q <= '0;
    else if (load_en) pc_q <= pc_next;
  end

  p_reset_r1: assert property (@(posedge clk) rst |=> pc_q == '0);
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!wr && !wr_cond) |=> $stable(pc_q));
  p_cond_miss_r6: assert property (@(posedge clk) disable iff (rst)
    (!wr && wr_cond && !zero) |=> $stable(pc_q));
  p_cond_hit_r6: assert property (@(posedge clk) disable iff (rst)
    branch_taken |=> pc_q == $past(pc_next));
  p_both_r8: assert property (@(posedge clk) disable iff (rst)
    (wr && wr_cond) |=> pc_q == $past(pc_next));
endmodule

// File: rtl/pcx_exc_regs.sv
module pcx_exc_regs
  import pcx_pkg::*;
#(
  parameter int CAUSE_W = XLEN
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               epc_wr,
  input  logic               cause_wr,
  input  logic               int_cause,
  input  logic [XLEN-1:0]    ret_addr,
  output logic [XLEN-1:0]    epc_q,
  output logic [CAUSE_W-1:0] cause_q
);
  logic [CAUSE_W-1:0] cause_word;

  generate
    if (CAUSE_W > 1) begin : g_pad
      assign cause_word = {{(CAUSE_W-1){1'b0}}, int_cause};
    end else begin : g_bit
      assign cause_word = int_cause;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      epc_q   <= '0;
      cause_q <= '0;
    end else begin
      if (epc_wr)   epc_q   <= ret_addr;
      if (cause_wr) cause_q <= cause_word;
    end
  end

  p_epc_load_r9: assert property (@(posedge clk) disable iff (rst)
    epc_wr |=> epc_q == $past(ret_addr));
  p_epc_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !epc_wr |=> $stable(epc_q));
  p_cause_bit_r10: assert property (@(posedge clk) disable iff (rst)
    cause_wr |=> (cause_q[0] == $past(int_cause)) && ($countones(cause_q) <= 1));
  p_cause_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !cause_wr |=> $stable(cause_q));
endmodule

// File: rtl/pcx_unit.sv
module pcx_unit
  import pcx_pkg::*;
#(
  parameter logic [31:0] EXC_VECTOR = 32'h8000_0180
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] alu_result,
  input  logic [31:0] alu_out_reg,
  input  logic [25:0] ir_target,
  input  logic        alu_zero,
  input  logic [1:0]  pc_src,
  input  logic        pc_wr,
  input  logic        pc_wr_cond,
  input  logic        epc_wr,
  input  logic        cause_wr,
  input  logic        int_cause,
  output logic [31:0] pc_q,
  output logic [31:0] epc_q,
  output logic [31:0] cause_q
);
  pc_src_e     src_sel;
  logic [31:0] pc_next;
  logic        pc_load_ev;

  assign src_sel    = pc_src_e'(pc_src);
  assign pc_load_ev = pc_wr | (pc_wr_cond & alu_zero);

  pcx_next_sel #(.EXC_VECTOR(EXC_VECTOR)) u_sel (
    .pc_cur(pc_q), .alu_result(alu_result), .alu_out_reg(alu_out_reg),
    .ir_target(ir_target), .src(src_sel), .pc_next(pc_next)
  );

  pcx_pc_reg u_pc (
    .clk(clk), .rst(rst), .wr(pc_wr), .wr_cond(pc_wr_cond), .zero(alu_zero),
    .pc_next(pc_next), .pc_q(pc_q)
  );

  pcx_exc_regs #(.CAUSE_W(32)) u_exc (
    .clk(clk), .rst(rst), .epc_wr(epc_wr), .cause_wr(cause_wr),
    .int_cause(int_cause), .ret_addr(alu_result), .epc_q(epc_q), .cause_q(cause_q)
  );

  p_seq_r2: assert property (@(posedge clk) disable iff (rst)
    (pc_load_ev && pc_src == 2'b00) |=> pc_q == $past(alu_result));
  p_branch_r3: assert property (@(posedge clk) disable iff (rst)
    (pc_load_ev && pc_src == 2'b01) |=> pc_q == $past(alu_out_reg));
  p_jump_r4: assert property (@(posedge clk) disable iff (rst)
    (pc_load_ev && pc_src == 2'b10) |=>
      pc_q == {$past(pc_q[31:28]), $past(ir_target), 2'b00});
  p_vector_r5: assert property (@(posedge clk) disable iff (rst)
    (pc_load_ev && pc_src == 2'b11) |=> pc_q == EXC_VECTOR);
endmodule

// File: tb/pcx_unit_tb.sv
`timescale 1ns/1ps
module pcx_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] alu_result, alu_out_reg;
  logic [25:0] ir_target;
  logic        alu_zero;
  logic [1:0]  pc_src;
  logic        pc_wr, pc_wr_cond, epc_wr, cause_wr, int_cause;
  logic [31:0] pc_q, epc_q, cause_q;

  int vectors = 0;
  int errors  = 0;
  logic [31:0] m_pc = 0, m_epc = 0, m_cause = 0;

  always #2.5 clk = ~clk;

  pcx_unit u_dut (
    .clk(clk), .rst(rst), .alu_result(alu_result), .alu_out_reg(alu_out_reg),
    .ir_target(ir_target), .alu_zero(alu_zero), .pc_src(pc_src), .pc_wr(pc_wr),
    .pc_wr_cond(pc_wr_cond), .epc_wr(epc_wr), .cause_wr(cause_wr),
    .int_cause(int_cause), .pc_q(pc_q), .epc_q(epc_q), .cause_q(cause_q)
  );

  function automatic logic [31:0] exp_next(input logic [31:0] cur);
    case (pc_src)
      2'd0:    return alu_result;
      2'd1:    return alu_out_reg;
      2'd2:    return (cur & 32'hF000_0000) | ({6'd0, ir_target} << 2);
      default: return 32'h8000_0180;
    endcase
  endfunction

  function automatic string pc_tag();
    if (pc_wr && pc_wr_cond) return "R8";
    if (pc_wr_cond && !pc_wr) return "R6";
    if (!pc_wr) return "R7";
    case (pc_src)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive on the falling edge, compute the model, check 1 ns after the rising edge.
  task automatic step();
    string t;
    t = rst ? "R1" : pc_tag();
    if (rst) begin
      m_pc = 0; m_epc = 0; m_cause = 0;
    end else begin
      if (pc_wr || (pc_wr_cond && alu_zero)) m_pc = exp_next(m_pc);
      if (epc_wr) m_epc = alu_result;
      if (cause_wr) m_cause = int_cause ? 32'd1 : 32'd0;
    end
    @(posedge clk); #1;
    cmp(t, pc_q, m_pc);
    cmp(rst ? "R1" : "R9", epc_q, m_epc);
    cmp(rst ? "R1" : "R10", cause_q, m_cause);
    @(negedge clk);
  endtask

  task automatic drive(input logic [1:0] s, input logic w, input logic wc,
                       input logic z, input logic ew, input logic cw, input logic ic);
    alu_result  = $urandom;
    alu_out_reg = $urandom;
    ir_target   = 26'($urandom);
    pc_src = s; pc_wr = w; pc_wr_cond = wc; alu_zero = z;
    epc_wr = ew; cause_wr = cw; int_cause = ic;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1;
    drive(2'd3, 1, 1, 1, 1, 1, 1);
    @(negedge clk);
    step();                                 // R1: reset wins over all writes
    step();
    rst = 1'b0;
    drive(2'd0, 1, 0, 0, 0, 0, 0); step(); // R2
    drive(2'd1, 1, 0, 0, 0, 0, 0); step(); // R3
    drive(2'd2, 1, 0, 0, 0, 0, 0); step(); // R4 with segment 0
    drive(2'd0, 1, 0, 0, 0, 0, 0); alu_result = 32'hA000_0004; step();
    drive(2'd2, 1, 0, 0, 0, 0, 0); ir_target = 26'h3FF_FFFF; step(); // R4 keeps A
    drive(2'd3, 1, 0, 0, 0, 0, 0); step(); // R5
    drive(2'd1, 0, 1, 0, 0, 0, 0); step(); // R6 not taken
    drive(2'd1, 0, 1, 1, 0, 0, 0); step(); // R6 taken
    drive(2'd3, 0, 0, 1, 0, 0, 0); step(); // R7 ignores zero and source
    drive(2'd0, 1, 1, 0, 0, 0, 0); step(); // R8
    drive(2'd1, 1, 1, 1, 0, 0, 0); step(); // R8
    drive(2'd3, 1, 0, 0, 1, 1, 1); step(); // R9, R10 overflow
    drive(2'd0, 0, 0, 0, 0, 1, 0); step(); // R10 undefined instruction
    drive(2'd0, 0, 0, 0, 0, 0, 1); step(); // R9/R10 hold
    for (int i = 0; i < 600; i++) begin
      drive(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom));
      rst = ($urandom % 50) == 0;
      step();
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule